// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel that sits beside a timer counter. It receives the running count and the counter's update pulse. In output mode it compares the count with its compare register and drives a waveform pin. A 3-bit action code selects what the pin does: hold its level, go high or low on a match, toggle on a match, be forced low or high, or run as one of two pulse-width modulators. An enable bit gates the pin and a polarity bit inverts it.

In input mode the same register receives a copy of the count whenever the selected edge appears on the input pin. The pin is first passed through a synchronizer. A 2-bit code selects the rising edge, the falling edge or both edges. A flag records that a capture happened. A second flag records that a capture arrived while the first flag was still set. Software reaches four registers over a simple write-enable/address/data bus, and reads them back combinationally.

Top module: `tmr_ccx_chan`

## Requirements
- R1: After reset all four registers read as zero and `oc_o` is low.
- R2: Address 0 holds the mode word: bits [1:0] select the direction, bit 2 enables preload and bits [6:4] hold the output action. A direction of 00 selects output mode. Any other value selects input capture, and `oc_o` then stays low.
- R3: In output mode a count equal to the active compare value makes the internal reference go high (action 001), go low (010) or invert (011) at the next clock edge. A count that does not match leaves the reference unchanged.
- R4: Action 000 holds the reference at its present level. Action 100 forces it low and action 101 forces it high, whatever the count.
- R5: Action 110 makes the reference high while count < compare and low otherwise. Action 111 is the inverse.
- R6: Address 1 holds bit 0 = enable, bit 1 = polarity and bit 3 = edge-extend. In output mode, `oc_o` is low while enable is 0. Otherwise `oc_o` is the reference, inverted when polarity is 1.
- R7: Address 2 is the compare/capture value. With preload off, a write takes effect at once. With preload on, a write goes to a shadow, and the active value (the one read back and compared) changes only on `upd_i`.
- R8: In input mode with enable 1, the code {edge-extend, polarity} selects the capture edge: 00 rising, 01 falling, 10 rising, 11 both. With enable 0 nothing is captured.
- R9: A capture copies `cnt_i` into address 2 and sets status bit 0. A capture while bit 0 is already set also sets status bit 1. Writing a 1 to a status bit at address 3 clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Current timer count |
| upd_i | input | 1 | Counter update event pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data, combinational |
| ic_i | input | 1 | Capture input pin, asynchronous |
| oc_o | output | 1 | Waveform output pin |

## Verification
The assertions check several properties on every cycle. Forced-high output drives the reference high on the following cycle. The first PWM action follows the previous cycle's count-versus-compare result. A preloaded compare value never moves without an update or a capture. Every capture loads the count and raises the capture flag, and overcapture only rises while the capture flag is already set. The directed scenarios cover the rest, because those behaviours depend on a sequence of register writes and pin activity. These include the edge-selection codes (the reserved code among them), the gating and polarity of the pin, the match actions for set, clear and toggle, and the clearing of the flags by writing ones.

// File: rtl/ccx_pkg.sv
package ccx_pkg;
  typedef enum logic [2:0] {
    OCM_FROZEN = 3'b000,
    OCM_SET    = 3'b001,
    OCM_CLR    = 3'b010,
    OCM_TGL    = 3'b011,
    OCM_LO     = 3'b100,
    OCM_HI     = 3'b101,
    OCM_PWM1   = 3'b110,
    OCM_PWM2   = 3'b111
  } ocm_e;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_CCR  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef struct packed {
    logic [1:0] dir;
    logic       pre;
    ocm_e       ocm;
    logic       en;
    logic       pol;
    logic       np;
  } cfg_t;
endpackage

// File: rtl/ccx_regs.sv
module ccx_regs
  import ccx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             upd_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             cap_evt_i,
  output cfg_t             cfg_o,
  output logic [CNT_W-1:0] ccr_o,
  output logic             cap_flag_o,
  output logic             ovc_flag_o
);
  localparam int MODE_W = 7;
  localparam int EN_W   = 4;
  localparam int STAT_W = 2;

  cfg_t             cfg_q;
  logic [CNT_W-1:0] ccr_q, ccr_sh_q;
  logic             cap_q, ovc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '{dir: 2'b00, pre: 1'b0, ocm: OCM_FROZEN, en: 1'b0, pol: 1'b0, np: 1'b0};
      ccr_q    <= '0;
      ccr_sh_q <= '0;
      cap_q    <= 1'b0;
      ovc_q    <= 1'b0;
    end else begin
      if (upd_i && cfg_q.pre) ccr_q <= ccr_sh_q;
      if (we_i) begin
        unique case (addr_i)
          A_MODE: begin
            cfg_q.dir <= wdata_i[1:0];
            cfg_q.pre <= wdata_i[2];
            cfg_q.ocm <= ocm_e'(wdata_i[6:4]);
          end
          A_EN: begin
            cfg_q.en  <= wdata_i[0];
            cfg_q.pol <= wdata_i[1];
            cfg_q.np  <= wdata_i[3];
          end
          A_CCR: begin
            ccr_sh_q <= wdata_i;
            if (!cfg_q.pre) ccr_q <= wdata_i;
          end
          default: begin
            if (wdata_i[0]) cap_q <= 1'b0;
            if (wdata_i[1]) ovc_q <= 1'b0;
          end
        endcase
      end
      // hardware capture outranks software writes in the same cycle
      if (cap_evt_i) begin
        ccr_q    <= cnt_i;
        ccr_sh_q <= cnt_i;
        cap_q    <= 1'b1;
        if (cap_q) ovc_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_MODE:  rdata_o[MODE_W-1:0] = {cfg_q.ocm, 1'b0, cfg_q.pre, cfg_q.dir};
      A_EN:    rdata_o[EN_W-1:0]   = {cfg_q.np, 1'b0, cfg_q.pol, cfg_q.en};
      A_CCR:   rdata_o             = ccr_q;
      default: rdata_o[STAT_W-1:0] = {ovc_q, cap_q};
    endcase
  end

  assign cfg_o      = cfg_q;
  assign ccr_o      = ccr_q;
  assign cap_flag_o = cap_q;
  assign ovc_flag_o = ovc_q;
endmodule

// File: rtl/ccx_insync.sv
module ccx_insync
  import ccx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ic_i,
  input  cfg_t cfg_i,
  output logic cap_evt_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic            cur, prv, rise, fall, hit;

  genvar g;
  generate
    for (g = 0; g < SH_W; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[g] <= 1'b0;
        else if (g == 0) sh_q[g] <= ic_i;
        else sh_q[g] <= sh_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign cur  = sh_q[SYNC_STAGES-1];
  assign prv  = sh_q[SYNC_STAGES];
  assign rise = cur & ~prv;
  assign fall = ~cur & prv;

  always_comb begin
    unique case ({cfg_i.np, cfg_i.pol})
      2'b01:   hit = fall;
      2'b11:   hit = rise | fall;
      default: hit = rise;  // 00 and the reserved 10
    endcase
  end

  assign cap_evt_o = (cfg_i.dir != 2'b00) & cfg_i.en & hit;
endmodule

// File: rtl/ccx_outgen.sv
module ccx_outgen
  import ccx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ccr_i,
  input  cfg_t             cfg_i,
  output logic             ref_o,
  output logic             oc_o
);
  logic ref_q;
  logic match, below, out_mode;

  assign match    = (cnt_i == ccr_i);
  assign below    = (cnt_i < ccr_i);
  assign out_mode = (cfg_i.dir == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
    end else if (out_mode) begin
      unique case (cfg_i.ocm)
        OCM_SET:  if (match) ref_q <= 1'b1;
        OCM_CLR:  if (match) ref_q <= 1'b0;
        OCM_TGL:  if (match) ref_q <= ~ref_q;
        OCM_LO:   ref_q <= 1'b0;
        OCM_HI:   ref_q <= 1'b1;
        OCM_PWM1: ref_q <= below;
        OCM_PWM2: ref_q <= ~below;
        default:  ref_q <= ref_q;
      endcase
    end
  end

  assign ref_o = ref_q;
  assign oc_o  = (out_mode && cfg_i.en) ? (ref_q ^ cfg_i.pol) : 1'b0;
endmodule

// File: rtl/tmr_ccx_chan.sv
module tmr_ccx_chan
  import ccx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             upd_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  input  logic             ic_i,
  output logic             oc_o
);
  cfg_t             cfg;
  logic [CNT_W-1:0] ccr;
  logic             cap_evt, cap_flag, ovc_flag, oc_ref;

  ccx_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt_i),
    .upd_i      (upd_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .cap_evt_i  (cap_evt),
    .cfg_o      (cfg),
    .ccr_o      (ccr),
    .cap_flag_o (cap_flag),
    .ovc_flag_o (ovc_flag)
  );

  ccx_insync #(.SYNC_STAGES(SYNC_STAGES)) u_insync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ic_i      (ic_i),
    .cfg_i     (cfg),
    .cap_evt_o (cap_evt)
  );

  ccx_outgen #(.CNT_W(CNT_W)) u_outgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt_i),
    .ccr_i  (ccr),
    .cfg_i  (cfg),
    .ref_o  (oc_ref),
    .oc_o   (oc_o)
  );
endmodule

// File: rtl/ccx_chk.sv
module ccx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic             upd_i,
  input logic [1:0]       dir_i,
  input logic             pre_i,
  input logic [2:0]       ocm_i,
  input logic             ref_i,
  input logic [CNT_W-1:0] ccr_i,
  input logic             cap_evt_i,
  input logic             cap_flag_i,
  input logic             ovc_flag_i
);
  p_force_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == 2'b00 && ocm_i == 3'b101) |=> ref_i);

  p_pwm1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == 2'b00 && ocm_i == 3'b110) |=> (ref_i == $past(cnt_i < ccr_i)));

  p_preload_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && !upd_i && !cap_evt_i) |=> $stable(ccr_i));

  p_capture_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> (ccr_i == $past(cnt_i)) && cap_flag_i);

  p_overcap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovc_flag_i) |-> $past(cap_flag_i));

  p_capture_dir_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |-> (dir_i != 2'b00));
endmodule

bind tmr_ccx_chan ccx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_i      (cnt_i),
  .upd_i      (upd_i),
  .dir_i      (cfg.dir),
  .pre_i      (cfg.pre),
  .ocm_i      (cfg.ocm),
  .ref_i      (oc_ref),
  .ccr_i      (ccr),
  .cap_evt_i  (cap_evt),
  .cap_flag_i (cap_flag),
  .ovc_flag_i (ovc_flag)
);

// File: tb/tb_tmr_ccx_chan.sv
module tb_tmr_ccx_chan;
  localparam int CLK_PER = 10;
  localparam int CNT_W   = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic             upd = 1'b0;
  logic             we = 1'b0;
  logic [1:0]       addr = 2'd0;
  logic [CNT_W-1:0] wdata = '0;
  logic [CNT_W-1:0] rdata;
  logic             ic = 1'b0;
  logic             oc;

  int total = 0;
  int bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  tmr_ccx_chan #(.CNT_W(CNT_W)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cnt_i       (cnt),
    .upd_i       (upd),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .ic_i        (ic),
    .oc_o        (oc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // mode word: {ocm[2:0], 0, pre, dir[1:0]}
  function automatic logic [CNT_W-1:0] mw(input logic [2:0] m, input logic p, input logic [1:0] d);
    return CNT_W'({m, 1'b0, p, d});
  endfunction

  task automatic t_reset;
    logic [CNT_W-1:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reg", 32'(v), 32'h0);
    end
    chk("R1 oc", 32'(oc), 32'h0);
  endtask

  task automatic t_match;
    logic [CNT_W-1:0] v;
    wr(2'd2, 16'd10);
    rd(2'd2, v);
    chk("R7 direct write", 32'(v), 32'd10);
    wr(2'd1, 16'h1);
    wr(2'd0, mw(3'b100, 1'b0, 2'b00));
    step();
    chk("R4 force low", 32'(oc), 32'h0);
    rd(2'd0, v);
    chk("R2 mode readback", 32'(v), 32'h40);
    wr(2'd0, mw(3'b001, 1'b0, 2'b00));
    cnt = 16'd5; step();
    chk("R3 set no match", 32'(oc), 32'h0);
    cnt = 16'd10; step();
    chk("R3 set on match", 32'(oc), 32'h1);
    wr(2'd0, mw(3'b010, 1'b0, 2'b00));
    step();
    chk("R3 clear on match", 32'(oc), 32'h0);
    wr(2'd0, mw(3'b011, 1'b0, 2'b00));
    step();
    chk("R3 toggle a", 32'(oc), 32'h1);
    step();
    chk("R3 toggle b", 32'(oc), 32'h0);
    cnt = 16'd11; step();
    chk("R3 toggle no match", 32'(oc), 32'h0);
  endtask

  task automatic t_force_frozen;
    wr(2'd0, mw(3'b101, 1'b0, 2'b00));
    cnt = 16'd3; step();
    chk("R4 force high", 32'(oc), 32'h1);
    wr(2'd0, mw(3'b000, 1'b0, 2'b00));
    cnt = 16'd10; step(2);
    chk("R4 frozen holds", 32'(oc), 32'h1);
  endtask

  task automatic t_pwm;
    wr(2'd0, mw(3'b110, 1'b0, 2'b00));
    cnt = 16'd9; step();
    chk("R5 pwm1 below", 32'(oc), 32'h1);
    cnt = 16'd10; step();
    chk("R5 pwm1 equal", 32'(oc), 32'h0);
    cnt = 16'd15; step();
    chk("R5 pwm1 above", 32'(oc), 32'h0);
    wr(2'd0, mw(3'b111, 1'b0, 2'b00));
    cnt = 16'd9; step();
    chk("R5 pwm2 below", 32'(oc), 32'h0);
    cnt = 16'd10; step();
    chk("R5 pwm2 equal", 32'(oc), 32'h1);
  endtask

  task automatic t_gate_pol;
    wr(2'd0, mw(3'b101, 1'b0, 2'b00));
    step();
    chk("R6 enabled high", 32'(oc), 32'h1);
    wr(2'd1, 16'h0);
    chk("R6 gated off", 32'(oc), 32'h0);
    wr(2'd1, 16'h3);
    chk("R6 inverted high", 32'(oc), 32'h0);
    wr(2'd0, mw(3'b100, 1'b0, 2'b00));
    step();
    chk("R6 inverted low", 32'(oc), 32'h1);
    wr(2'd1, 16'h1);
  endtask

  task automatic t_input_mode;
    wr(2'd0, mw(3'b101, 1'b0, 2'b00));
    step();
    chk("R2 output mode", 32'(oc), 32'h1);
    wr(2'd0, mw(3'b101, 1'b0, 2'b01));
    step();
    chk("R2 input mode quiet", 32'(oc), 32'h0);
  endtask

  task automatic t_preload;
    logic [CNT_W-1:0] v;
    wr(2'd0, mw(3'b110, 1'b1, 2'b00));
    wr(2'd2, 16'd50);
    rd(2'd2, v);
    chk("R7 shadow hidden", 32'(v), 32'd10);
    cnt = 16'd20; step();
    chk("R7 old compare used", 32'(oc), 32'h0);
    upd = 1'b1; step(); upd = 1'b0;
    rd(2'd2, v);
    chk("R7 loaded on update", 32'(v), 32'd50);
    step();
    chk("R7 new compare used", 32'(oc), 32'h1);
  endtask

  task automatic t_capture;
    logic [CNT_W-1:0] v;
    wr(2'd0, mw(3'b000, 1'b0, 2'b01));
    wr(2'd1, 16'h1);
    wr(2'd3, 16'h3);
    cnt = 16'd100; ic = 1'b1; step(4);
    rd(2'd2, v); chk("R8 rising captured", 32'(v), 32'd100);
    rd(2'd3, v); chk("R9 flag set", 32'(v), 32'h1);
    wr(2'd3, 16'h1);
    cnt = 16'd200; ic = 1'b0; step(4);
    rd(2'd2, v); chk("R8 falling ignored", 32'(v), 32'd100);
    rd(2'd3, v); chk("R9 flag cleared", 32'(v), 32'h0);
    wr(2'd1, 16'h3);
    cnt = 16'd300; ic = 1'b1; step(4);
    rd(2'd3, v); chk("R8 rising ignored", 32'(v), 32'h0);
    ic = 1'b0; step(4);
    rd(2'd2, v); chk("R8 falling captured", 32'(v), 32'd300);
    wr(2'd1, 16'hB);
    wr(2'd3, 16'h3);
    cnt = 16'd400; ic = 1'b1; step(4);
    rd(2'd2, v); chk("R8 both rise", 32'(v), 32'd400);
    rd(2'd3, v); chk("R9 no overcapture yet", 32'(v), 32'h1);
    cnt = 16'd500; ic = 1'b0; step(4);
    rd(2'd2, v); chk("R8 both fall", 32'(v), 32'd500);
    rd(2'd3, v); chk("R9 overcapture", 32'(v), 32'h3);
    wr(2'd3, 16'h3);
    rd(2'd3, v); chk("R9 clear both", 32'(v), 32'h0);
    wr(2'd1, 16'h9);
    cnt = 16'd600; ic = 1'b1; step(4);
    rd(2'd2, v); chk("R8 reserved rising", 32'(v), 32'd600);
    cnt = 16'd700; ic = 1'b0; step(4);
    rd(2'd2, v); chk("R8 reserved no fall", 32'(v), 32'd600);
    wr(2'd1, 16'hA);
    cnt = 16'd800; ic = 1'b1; step(4);
    ic = 1'b0; step(4);
    rd(2'd2, v); chk("R8 disabled no capture", 32'(v), 32'd600);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_match();
    t_force_frozen();
    t_pwm();
    t_gate_pol();
    t_input_mode();
    t_preload();
    t_capture();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule